// File: doc/BRIEF.md
# LIN Header Break and Baud Measurement Unit

This unit sits on the receive side of a LIN slave. It watches the bus level, which is already sampled into the system clock domain, for a long dominant (low) stretch that marks the start of a frame. Once that stretch ends, it measures the synchronisation byte (0x55) that follows. From that byte it derives the number of system clocks in one bit, so a slave running on an imprecise oscillator can track the master's rate.

The bit time comes from the distance between the first and the fifth falling edge of the sync byte. That distance covers eight bits, so the count is shifted right by three. Each of the four edge-to-edge gaps is also compared with a quarter of the total. If any gap strays too far, the measurement is thrown away and an error pulse is raised instead of the header strobe. The stored bit time sets the minimum low length for the next break, so detection follows the master's rate from frame to frame.

Top module: `lin_baud_det`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `bit_time` equals `INIT_BIT`, and `hdr_ready` and `sync_err` are 0.
- R2: A low run counts as a break only if it lasts at least `BRK_BITS` × `bit_time` clock cycles before the line returns high. A run that is one cycle shorter is ignored.
- R3: The break threshold always uses the current `bit_time`. After a successful measurement, the next break is judged by the newly measured value.
- R4: After a break, the sync measurement opens on the first falling edge. On the fifth falling edge, `bit_time` loads floor(span/8), where span is the number of cycles between the first and fifth edges. `hdr_ready` pulses for one cycle in the cycle after the fifth edge is sampled.
- R5: The four edge-to-edge gaps must each lie within floor(span/16) of floor(span/4), and span must be at least 8. Otherwise `sync_err` pulses for one cycle, `hdr_ready` stays 0 and `bit_time` keeps its old value.
- R6: The cycle counters saturate at 2^`CNT_W`−1 instead of wrapping. If the sync timer reaches that value before the fifth edge, `sync_err` pulses once, `bit_time` is unchanged and the unit returns to break hunting.
- R7: After a header strobe or a sync error, falling edges have no effect: no strobe and no change to `bit_time` until a new break has been detected.
- R8: `hdr_ready` and `sync_err` are never high in the same cycle, and neither stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; `rxd` is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Synchronised bus level, 0 = dominant |
| bit_time | output | CNT_W | Measured clock cycles per bit |
| hdr_ready | output | 1 | One-cycle pulse when a valid break and sync pair is complete |
| sync_err | output | 1 | One-cycle pulse when the sync byte is rejected or times out |

## Verification
The acceptance test and the loading of a new bit time happen in the same cycle: the cycle of the fifth falling edge. The bench drives sync bytes whose first gap lies just inside and just outside the tolerance band. For each case it checks that the strobe and the new bit time appear together, and that a rejected byte raises the error pulse while leaving the bit time untouched. A second pair is also covered: the break threshold reads the bit time that was just written. A break that was long enough under the old rate must then be refused under the new one.

// File: rtl/lin_baud_pkg.sv
`timescale 1ns/1ps
package lin_baud_pkg;
    // falling edges in the 0x55 byte give this many gaps
    localparam int NSEG = 4;

    typedef enum logic [1:0] {
        ST_HUNT,
        ST_DELIM,
        ST_SYNC
    } lbd_state_e;
endpackage

// File: rtl/lin_fall_det.sv
`timescale 1ns/1ps
module lin_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl,
    output logic fall
);
    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= lvl;
    end

    assign fall = prev_q & ~lvl;
endmodule

// File: rtl/lin_span_chk.sv
`timescale 1ns/1ps
module lin_span_chk #(
    parameter int W    = 16,
    parameter int NSEG = 4
) (
    input  logic [NSEG-1:0][W-1:0] segs,
    output logic                   ok,
    output logic [W-1:0]           bit_len
);
    localparam int SW  = W + $clog2(NSEG);
    localparam int QSH = $clog2(NSEG);
    localparam int TSH = QSH + 2;
    localparam int BSH = QSH + 1;

    logic [SW-1:0]   span;
    logic [SW-1:0]   qtr;
    logic [SW-1:0]   tol;
    logic [NSEG-1:0] seg_ok;

    always_comb begin
        span = '0;
        for (int i = 0; i < NSEG; i++) span = span + SW'(segs[i]);
    end

    assign qtr = span >> QSH;
    assign tol = span >> TSH;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        logic [SW-1:0] v;
        logic [SW-1:0] dev;
        assign v         = SW'(segs[g]);
        assign dev       = (v > qtr) ? (v - qtr) : (qtr - v);
        assign seg_ok[g] = (dev <= tol);
    end

    assign ok      = (&seg_ok) && (span >= SW'(2 * NSEG));
    assign bit_len = W'(span >> BSH);
endmodule

// File: rtl/lin_baud_det.sv
`timescale 1ns/1ps
module lin_baud_det
    import lin_baud_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int INIT_BIT = 52,
    parameter int BRK_BITS = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    output logic [CNT_W-1:0] bit_time,
    output logic             hdr_ready,
    output logic             sync_err
);
    localparam logic [CNT_W-1:0] CMAX = '1;
    localparam int TW = CNT_W + $clog2(BRK_BITS + 1);
    localparam int EW = $clog2(NSEG);

    typedef struct packed {
        lbd_state_e                    st;
        logic [CNT_W-1:0]              low;
        logic [CNT_W-1:0]              tmr;
        logic [CNT_W-1:0]              seg;
        logic [EW-1:0]                 eidx;
        logic [NSEG-2:0][CNT_W-1:0]    sp;
        logic [CNT_W-1:0]              bit_t;
        logic                          hdr;
        logic                          err;
    } lbd_regs_t;

    lbd_regs_t r_q, r_d;

    logic                      fall;
    logic                      span_ok;
    logic [CNT_W-1:0]          meas;
    logic [NSEG-1:0][CNT_W-1:0] segv;
    logic [TW-1:0]             thr;

    lin_fall_det u_fall (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  (rxd),
        .fall (fall)
    );

    assign segv = {r_q.seg, r_q.sp};

    lin_span_chk #(.W(CNT_W), .NSEG(NSEG)) u_span (
        .segs   (segv),
        .ok     (span_ok),
        .bit_len(meas)
    );

    assign thr = TW'(r_q.bit_t) * TW'(BRK_BITS);

    always_comb begin
        r_d     = r_q;
        r_d.hdr = 1'b0;
        r_d.err = 1'b0;
        r_d.low = rxd ? '0 : ((r_q.low == CMAX) ? CMAX : r_q.low + 1'b1);

        unique case (r_q.st)
            ST_HUNT: begin
                if (rxd && (TW'(r_q.low) >= thr)) r_d.st = ST_DELIM;
            end
            ST_DELIM: begin
                if (fall) begin
                    r_d.st   = ST_SYNC;
                    r_d.tmr  = CNT_W'(1);
                    r_d.seg  = CNT_W'(1);
                    r_d.eidx = '0;
                end
            end
            ST_SYNC: begin
                r_d.tmr = (r_q.tmr == CMAX) ? CMAX : r_q.tmr + 1'b1;
                r_d.seg = (r_q.seg == CMAX) ? CMAX : r_q.seg + 1'b1;
                if (fall) begin
                    r_d.seg = CNT_W'(1);
                    if (r_q.eidx == EW'(NSEG - 1)) begin
                        r_d.st = ST_HUNT;
                        if (span_ok) begin
                            r_d.bit_t = meas;
                            r_d.hdr   = 1'b1;
                        end else begin
                            r_d.err = 1'b1;
                        end
                    end else begin
                        r_d.sp[r_q.eidx] = r_q.seg;
                        r_d.eidx         = r_q.eidx + 1'b1;
                    end
                end else if (r_q.tmr == CMAX) begin
                    r_d.err = 1'b1;
                    r_d.st  = ST_HUNT;
                end
            end
            default: r_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.st    <= ST_HUNT;
            r_q.bit_t <= CNT_W'(INIT_BIT);
        end else begin
            r_q <= r_d;
        end
    end

    assign bit_time  = r_q.bit_t;
    assign hdr_ready = r_q.hdr;
    assign sync_err  = r_q.err;
endmodule

// File: rtl/lin_baud_det_chk.sv
`timescale 1ns/1ps
module lin_baud_det_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rxd,
    input logic [CNT_W-1:0] bit_time,
    input logic             hdr_ready,
    input logic             sync_err
);
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_ready && sync_err));                                         // R8
    AST_HDR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |=> !hdr_ready);                                         // R8
    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |=> !sync_err);                                           // R8
    AST_BIT_ONLY_ON_HDR: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_time != $past(bit_time)) |-> hdr_ready);                      // R5
    AST_HDR_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> !$past(rxd));                                        // R4
    AST_BIT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_ready |-> (bit_time != '0));                                   // R5
endmodule

bind lin_baud_det lin_baud_det_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rxd      (rxd),
    .bit_time (bit_time),
    .hdr_ready(hdr_ready),
    .sync_err (sync_err)
);

// File: tb/sim_lin_baud_det.sv
`timescale 1ns/1ps
module sim_lin_baud_det;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rxd = 1'b1;
    logic [CW-1:0] bit_time;
    logic          hdr_ready;
    logic          sync_err;

    int n_chk = 0;
    int n_bad = 0;
    int hdr_cnt = 0;
    int err_cnt = 0;

    always #10 clk = ~clk;

    lin_baud_det #(.CNT_W(CW), .INIT_BIT(20), .BRK_BITS(11)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .rxd      (rxd),
        .bit_time (bit_time),
        .hdr_ready(hdr_ready),
        .sync_err (sync_err)
    );

    always @(negedge clk) begin
        if (hdr_ready) hdr_cnt++;
        if (sync_err)  err_cnt++;
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(logic v, int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_break(int low_len);
        drive(1'b0, low_len);
        drive(1'b1, 40);
    endtask

    // four gaps, then the closing low (fifth edge) and the stop/idle high
    task automatic send_sync(int b, int s0, int s1, int s2, int s3,
                             output logic h, output logic e);
        int sp[4];
        sp = '{s0, s1, s2, s3};
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, sp[i] / 2);
            drive(1'b1, sp[i] - sp[i] / 2);
        end
        rxd = 1'b0;
        @(negedge clk);
        h = hdr_ready;
        e = sync_err;
        drive(1'b0, b - 1);
        drive(1'b1, 3 * b);
    endtask

    task automatic t_reset;
        chk("R1 bit_time in reset", int'(bit_time), 20);
        chk("R1 hdr in reset", int'(hdr_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bit_time after reset", int'(bit_time), 20);
        chk("R1 err after reset", int'(sync_err), 0);
    endtask

    task automatic t_nominal;
        logic h, e;
        send_break(260);
        send_sync(24, 48, 48, 48, 48, h, e);
        chk("R4 hdr at fifth edge", int'(h), 1);
        chk("R4 no err", int'(e), 0);
        chk("R4 bit_time 24", int'(bit_time), 24);
    endtask

    task automatic t_no_break;
        logic h, e;
        int h0;
        h0 = hdr_cnt;
        send_sync(20, 40, 40, 40, 40, h, e);
        chk("R7 no hdr without break", hdr_cnt - h0, 0);
        chk("R7 bit_time kept", int'(bit_time), 24);
    endtask

    task automatic t_thr_follows;
        logic h, e;
        int h0;
        h0 = hdr_cnt;
        send_break(250);
        send_sync(20, 40, 40, 40, 40, h, e);
        chk("R3 250-cycle low refused at bit 24", hdr_cnt - h0, 0);
        chk("R3 bit_time kept", int'(bit_time), 24);
    endtask

    task automatic t_exact;
        logic h, e;
        send_break(264);
        send_sync(20, 40, 40, 40, 40, h, e);
        chk("R2 exact threshold accepted", int'(h), 1);
        chk("R4 bit_time 20", int'(bit_time), 20);
    endtask

    task automatic t_short;
        logic h, e;
        int h0, e0;
        h0 = hdr_cnt;
        e0 = err_cnt;
        send_break(219);
        send_sync(20, 40, 40, 40, 40, h, e);
        chk("R2 one short refused", hdr_cnt - h0, 0);
        chk("R2 no err", err_cnt - e0, 0);
    endtask

    task automatic t_skew_in;
        logic h, e;
        send_break(260);
        send_sync(20, 48, 40, 40, 40, h, e);
        chk("R5 skew inside band hdr", int'(h), 1);
        chk("R4 span 168 gives 21", int'(bit_time), 21);
    endtask

    task automatic t_skew_out;
        logic h, e;
        int h0;
        h0 = hdr_cnt;
        send_break(260);
        send_sync(20, 56, 40, 40, 40, h, e);
        chk("R5 skew outside band err", int'(e), 1);
        chk("R8 no hdr with err", int'(h), 0);
        chk("R5 no hdr pulse", hdr_cnt - h0, 0);
        chk("R5 bit_time kept", int'(bit_time), 21);
    endtask

    task automatic t_saturate;
        int h0, e0;
        h0 = hdr_cnt;
        e0 = err_cnt;
        send_break(260);
        drive(1'b0, 20);
        drive(1'b1, 70000);
        chk("R6 timeout err once", err_cnt - e0, 1);
        chk("R6 no hdr", hdr_cnt - h0, 0);
        chk("R6 bit_time kept", int'(bit_time), 21);
    endtask

    task automatic t_rearm;
        logic h, e;
        send_break(260);
        send_sync(22, 44, 44, 44, 44, h, e);
        chk("R7 rearmed after error", int'(h), 1);
        chk("R7 bit_time 22", int'(bit_time), 22);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        drive(1'b1, 20);
        t_nominal();
        t_no_break();
        t_thr_follows();
        t_exact();
        t_short();
        t_skew_in();
        t_skew_out();
        t_saturate();
        t_rearm();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule